// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller for a successive-approximation analog-to-digital converter of `RES_BITS` bits (default 10). Software writes a start/busy bit, and the sequencer then drives the sample-and-hold switch, steps a trial code into an external DAC and reads back a one-bit comparator decision. It loads the finished code into a result register and raises a sticky completion flag. All sequencing advances on a single-cycle conversion-clock tick supplied from outside. A software abort is the only exception: it takes effect at the next system clock edge.

A start begins with an optional automatic acquisition phase. Its length is picked by a 3-bit select code. The holding capacitor is then disconnected and the code is resolved from the most significant bit downwards over `RES_BITS`+1 ticks. After every conversion, whether it completed or was aborted, a fixed two-tick recovery period keeps the switch open. The switch then reconnects so that the input is tracked again. In continuous mode a completed conversion restarts by itself once recovery ends.

Top module: `sar_seq`

## Requirements
- R1: A start write (`go_wr`=1, `go_wdata`=1) is accepted only if `adc_en` was already high in the previous clock cycle. A start in the same cycle that `adc_en` rises leaves `busy` at 0.
- R2: `acq_sel` sets the acquisition length in ticks: 0→0, 1→2, 2→4, 3→6, 4→8, 5→12, 6→16, 7→20. `hold_connect` is 1 during acquisition.
- R3: The conversion phase spans exactly `RES_BITS`+1 ticks, with `hold_connect` at 0. `busy` therefore stays 1 for acquisition length + `RES_BITS`+1 ticks after the start edge.
- R4: The first trial code on `dac_code` has only the top bit set (512 at default width). Bits are then decided from bit `RES_BITS`-1 down to bit 0. A bit is kept when `cmp_in`=1, meaning the input is at or above the trial code. `dac_code` changes only on a tick or on a start write.
- R5: On completion, `result` takes the resolved code, `busy` falls and `done_flag` rises, all at the same clock edge. With an ideal comparator, `result` equals the input value.
- R6: `done_flag` stays 1 until `flag_clr` is pulsed.
- R7: A clear write (`go_wr`=1, `go_wdata`=0) during conversion aborts it at the next clock edge. `result` then takes the bits decided so far, with all undecided bits 0, and `done_flag` is not set. A clear write during acquisition returns to idle at once.
- R8: After a completion or a conversion abort, `hold_connect` stays 0 for exactly 2 ticks and then returns to 1.
- R9: With `cont_mode`=1, `busy` rises again, with no write, at the second recovery tick after a completion. The new conversion produces a fresh result.
- R10: After reset, `busy`, `done_flag`, `result` and `dac_code` are 0. While `adc_en` is 0, `hold_connect` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_en | input | 1 | Converter enable |
| go_wr | input | 1 | Write strobe for the start/busy bit |
| go_wdata | input | 1 | Value written: 1 starts, 0 aborts |
| acq_sel | input | 3 | Acquisition-time select code |
| cont_mode | input | 1 | Automatic restart after each completion |
| tad_tick | input | 1 | Single-cycle conversion-clock enable |
| cmp_in | input | 1 | Comparator output: 1 when input ≥ trial code |
| flag_clr | input | 1 | Clears the completion flag |
| busy | output | 1 | Start/busy bit readback |
| hold_connect | output | 1 | Sample-and-hold switch closed |
| dac_code | output | RES_BITS | Trial code to the DAC |
| result | output | RES_BITS | Result buffer |
| done_flag | output | 1 | Sticky completion flag |

## Verification
The hardest situation to reach is an abort that lands on a chosen step in the middle of the bit trials. Stopping at a particular decided bit needs the clear write to arrive after an exact number of ticks. The bench generates the tick itself and counts the ticks it grants after the start edge. It then issues the clear write once every possible count from zero to ten has elapsed, with several input values. For each case it computes the partial code by masking the input to the bits decided so far.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ACQ   = 2'd1,
    PH_CONV  = 2'd2,
    PH_RECOV = 2'd3
  } phase_t;

  localparam int unsigned RECOV_TICKS = 2;
  localparam int unsigned ACQ_MAX     = 20;

  // 0,2,4,6,8 for codes 0..4, then 12,16,20
  function automatic int unsigned acq_ticks(input logic [2:0] sel);
    int unsigned s;
    s = int'(sel);
    if (s <= 4) return 2 * s;
    return 4 * (s - 2);
  endfunction

endpackage

// File: rtl/sar_acq_decode.sv
module sar_acq_decode #(
  parameter int CNT_W = 5
) (
  input  logic [2:0]       sel,
  output logic [CNT_W-1:0] ticks
);
  assign ticks = CNT_W'(sar_seq_pkg::acq_ticks(sel));
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic         cmp_in,
  output logic [N-1:0] code,
  output logic [N-1:0] decided,
  output logic [N-1:0] partial
);
  localparam logic [N-1:0] TOP_BIT = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] trial;

  assign partial = code & ~trial;
  assign decided = cmp_in ? code : partial;

  always_ff @(posedge clk) begin
    if (rst) begin
      code  <= '0;
      trial <= '0;
    end else if (load) begin
      code  <= TOP_BIT;
      trial <= TOP_BIT;
    end else if (step) begin
      code  <= decided | (trial >> 1);
      trial <= trial >> 1;
    end
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adc_en,
  input  logic                go_wr,
  input  logic                go_wdata,
  input  logic [2:0]          acq_sel,
  input  logic                cont_mode,
  input  logic                tad_tick,
  input  logic                cmp_in,
  input  logic                flag_clr,
  output logic                busy,
  output logic                hold_connect,
  output logic [RES_BITS-1:0] dac_code,
  output logic [RES_BITS-1:0] result,
  output logic                done_flag
);
  import sar_seq_pkg::*;

  localparam int CNT_MAX = (int'(ACQ_MAX) > RES_BITS) ? int'(ACQ_MAX) : RES_BITS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(RES_BITS);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
  localparam logic [CNT_W-1:0] REC_LEN   = CNT_W'(RECOV_TICKS);

  phase_t ph_q, ph_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, acq_len;
  logic busy_q, busy_n, chain_q, chain_n, en_q, hold_q, flag_q;
  logic sar_load, sar_step, res_we;
  logic [RES_BITS-1:0] res_q, res_d, code, decided, partial;
  logic wr_set, wr_clr, start_ok;

  sar_acq_decode #(.CNT_W(CNT_W)) i_dec (.sel(acq_sel), .ticks(acq_len));

  sar_approx_reg #(.N(RES_BITS)) i_sar (
    .clk(clk), .rst(rst), .load(sar_load), .step(sar_step), .cmp_in(cmp_in),
    .code(code), .decided(decided), .partial(partial)
  );

  assign wr_set   = go_wr && go_wdata;
  assign wr_clr   = go_wr && !go_wdata;
  assign start_ok = wr_set && adc_en && en_q;

  always_comb begin
    ph_n     = ph_q;
    cnt_n    = cnt_q;
    busy_n   = busy_q;
    chain_n  = chain_q;
    sar_load = 1'b0;
    sar_step = 1'b0;
    res_we   = 1'b0;
    res_d    = partial;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_ok) begin
          busy_n = 1'b1;
          if (acq_len == '0) begin
            ph_n = PH_CONV; cnt_n = '0; sar_load = 1'b1;
          end else begin
            ph_n = PH_ACQ; cnt_n = acq_len;
          end
        end
      end
      PH_ACQ: begin
        if (wr_clr) begin
          busy_n = 1'b0; ph_n = PH_IDLE;
        end else if (tad_tick) begin
          if (cnt_q == ONE) begin
            ph_n = PH_CONV; cnt_n = '0; sar_load = 1'b1;
          end else begin
            cnt_n = cnt_q - ONE;
          end
        end
      end
      PH_CONV: begin
        if (wr_clr) begin
          res_we = 1'b1; res_d = partial; busy_n = 1'b0;
          ph_n = PH_RECOV; cnt_n = REC_LEN; chain_n = 1'b0;
        end else if (tad_tick) begin
          if (cnt_q == LAST_STEP) begin
            res_we = 1'b1; res_d = decided; busy_n = 1'b0;
            ph_n = PH_RECOV; cnt_n = REC_LEN; chain_n = 1'b1;
          end else begin
            sar_step = (cnt_q != '0);
            cnt_n    = cnt_q + ONE;
          end
        end
      end
      PH_RECOV: begin
        if (start_ok) busy_n = 1'b1;
        if (wr_clr)   busy_n = 1'b0;
        if (tad_tick) begin
          if (cnt_q == ONE) begin
            if (busy_n || (chain_q && cont_mode)) begin
              busy_n = 1'b1;
              if (acq_len == '0) begin
                ph_n = PH_CONV; cnt_n = '0; sar_load = 1'b1;
              end else begin
                ph_n = PH_ACQ; cnt_n = acq_len;
              end
            end else begin
              ph_n = PH_IDLE;
            end
          end else begin
            cnt_n = cnt_q - ONE;
          end
        end
      end
      default: ph_n = PH_IDLE;
    endcase
    if (!adc_en) begin
      ph_n = PH_IDLE; cnt_n = '0; busy_n = 1'b0; chain_n = 1'b0;
      sar_load = 1'b0; sar_step = 1'b0; res_we = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      chain_q <= 1'b0;
      en_q    <= 1'b0;
      hold_q  <= 1'b0;
      flag_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      ph_q    <= ph_n;
      cnt_q   <= cnt_n;
      busy_q  <= busy_n;
      chain_q <= chain_n;
      en_q    <= adc_en;
      hold_q  <= adc_en && (ph_n == PH_IDLE || ph_n == PH_ACQ);
      if (res_we) res_q <= res_d;
      if (res_we && busy_q && !wr_clr) flag_q <= 1'b1;
      else if (flag_clr)               flag_q <= 1'b0;
    end
  end

  assign busy         = busy_q;
  assign hold_connect = hold_q;
  assign dac_code     = code;
  assign result       = res_q;
  assign done_flag    = flag_q;

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_BITS = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                adc_en,
  input logic                go_wr,
  input logic                go_wdata,
  input logic                tad_tick,
  input logic                flag_clr,
  input logic                busy,
  input logic                hold_connect,
  input logic [RES_BITS-1:0] dac_code,
  input logic                done_flag
);
  // R1
  early_start_chk: assert property (@(posedge clk) disable iff (rst)
    (go_wr && go_wdata && !busy && adc_en && !$past(adc_en)) |=> !busy);

  // R4
  code_pace_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_code) |-> ($past(tad_tick) || $past(go_wr)));

  // R5
  done_with_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> ($fell(busy) && !hold_connect));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done_flag && !flag_clr) |=> done_flag);

  // R7
  abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && $past(go_wr && !go_wdata)) |-> !$rose(done_flag));

  // R8
  recov_open_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |=> !hold_connect);
endmodule

bind sar_seq sar_seq_chk #(.RES_BITS(RES_BITS)) i_chk (
  .clk(clk), .rst(rst), .adc_en(adc_en), .go_wr(go_wr), .go_wdata(go_wdata),
  .tad_tick(tad_tick), .flag_clr(flag_clr), .busy(busy),
  .hold_connect(hold_connect), .dac_code(dac_code), .done_flag(done_flag)
);

// File: tb/test_sar_seq.sv
module test_sar_seq;
  localparam int NB   = 10;
  localparam int TDIV = 4;

  logic clk = 1'b0, rst = 1'b1, adc_en = 1'b0, go_wr = 1'b0, go_wdata = 1'b0;
  logic [2:0] acq_sel = 3'd0;
  logic cont_mode = 1'b0, tad_tick = 1'b0, flag_clr = 1'b0, cmp_in;
  logic busy, hold_connect, done_flag;
  logic [NB-1:0] dac_code, result;
  int vin = 0;
  int checks = 0, fails = 0, div = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    div <= (div == TDIV - 1) ? 0 : div + 1;
    tad_tick <= (div == TDIV - 2);
  end

  assign cmp_in = (vin >= int'(dac_code));

  sar_seq #(.RES_BITS(NB)) i_sar_seq (
    .clk(clk), .rst(rst), .adc_en(adc_en), .go_wr(go_wr), .go_wdata(go_wdata),
    .acq_sel(acq_sel), .cont_mode(cont_mode), .tad_tick(tad_tick), .cmp_in(cmp_in),
    .flag_clr(flag_clr), .busy(busy), .hold_connect(hold_connect),
    .dac_code(dac_code), .result(result), .done_flag(done_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int acq_len(input int s);
    return (s <= 4) ? 2 * s : 4 * (s - 2);
  endfunction

  task automatic wr(input logic d);
    @(negedge clk); go_wr = 1'b1; go_wdata = d;
    @(negedge clk); go_wr = 1'b0; #1;
  endtask

  task automatic clr_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0; #1;
  endtask

  // counts ticks granted while cond holds; ends at negedge+1
  task automatic count_while_busy(output int n);
    n = 0;
    for (int g = 0; g < 400; g++) begin
      if (tad_tick) n++;
      @(negedge clk); #1;
      if (!busy) break;
    end
  endtask

  task automatic count_until_hold(output int n);
    n = 0;
    for (int g = 0; g < 400; g++) begin
      if (tad_tick) n++;
      @(negedge clk); #1;
      if (hold_connect) break;
    end
  endtask

  task automatic count_until_busy(output int n);
    n = 0;
    for (int g = 0; g < 400; g++) begin
      if (tad_tick) n++;
      @(negedge clk); #1;
      if (busy) break;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    chk("R10 busy", busy, 0);
    chk("R10 flag", done_flag, 0);
    chk("R10 result", result, 0);
    chk("R10 dac", dac_code, 0);
    chk("R10 hold", hold_connect, 0);
    @(negedge clk); rst = 1'b0;

    // R1: start in the same cycle as enable is ignored
    @(negedge clk); adc_en = 1'b1; go_wr = 1'b1; go_wdata = 1'b1;
    @(negedge clk); go_wr = 1'b0; #1;
    chk("R1 same-cycle start", busy, 0);
    chk("R10 hold when enabled idle", hold_connect, 1);
    repeat (2) @(negedge clk);

    // R2 R3 R5 R8: every acquisition code, several inputs
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 5; k++) begin
        vin = (k == 0) ? 0 : (k == 1) ? 1023 : (k == 2) ? 512 : (k == 3) ? 511 : (s * 131 + 77) % 1024;
        acq_sel = 3'(s);
        wr(1'b1);
        chk("R1 accepted start", busy, 1);
        if (s == 0) chk("R4 first trial", dac_code, 512);
        else        chk("R2 hold in acquisition", hold_connect, 1);
        count_while_busy(n);
        chk("R3 busy ticks", n, acq_len(s) + NB + 1);
        chk("R5 result", result, vin);
        chk("R5 flag", done_flag, 1);
        chk("R3 hold open after conv", hold_connect, 0);
        count_until_hold(n);
        chk("R8 recovery ticks", n, 2);
        chk("R6 flag kept", done_flag, 1);
        clr_flag();
        chk("R6 flag cleared", done_flag, 0);
      end
    end

    // R5: exhaustive input sweep, no acquisition
    acq_sel = 3'd0;
    for (int v = 0; v < 1024; v++) begin
      vin = v;
      wr(1'b1);
      count_while_busy(n);
      chk("R5 sweep result", result, v);
      count_until_hold(n);
    end
    clr_flag();

    // R7: abort after each possible number of conversion ticks
    for (int t = 0; t <= NB; t++) begin
      for (int k = 0; k < 3; k++) begin
        int d, p;
        vin = (k == 0) ? 1023 : (k == 1) ? 678 : 341;
        acq_sel = 3'd0;
        wr(1'b1);
        n = 0;
        while (n < t) begin
          if (tad_tick) n++;
          @(negedge clk); #1;
        end
        wr(1'b0);
        d = (t > 0) ? t - 1 : 0;
        p = vin & ~((1 << (NB - d)) - 1);
        chk("R7 busy after abort", busy, 0);
        chk("R7 partial result", result, p);
        chk("R7 no flag", done_flag, 0);
        count_until_hold(n);
        chk("R8 recovery after abort", n, 2);
      end
    end

    // R7: abort during acquisition leaves result and flag untouched
    vin = 300; acq_sel = 3'd7;
    wr(1'b1);
    repeat (10) @(negedge clk);
    wr(1'b0);
    @(negedge clk); #1;
    chk("R7 acq abort busy", busy, 0);
    chk("R7 acq abort hold", hold_connect, 1);
    chk("R7 acq abort flag", done_flag, 0);

    // R9: continuous mode restarts after recovery
    cont_mode = 1'b1;
    for (int s = 0; s < 3; s++) begin
      acq_sel = 3'(s * 2);
      vin = 100 + s;
      wr(1'b1);
      count_while_busy(n);
      chk("R9 first result", result, vin);
      vin = 900 - s;
      count_until_busy(n);
      chk("R9 restart ticks", n, 2);
      count_while_busy(n);
      chk("R9 second busy ticks", n, acq_len(s * 2) + NB + 1);
      chk("R9 second result", result, vin);
      cont_mode = 1'b0;
      count_until_busy(n);
      chk("R9 stops when mode off", busy, 0);
      cont_mode = 1'b1;
      clr_flag();
    end
    cont_mode = 1'b0;

    // R10: disabling opens the switch
    @(negedge clk); adc_en = 1'b0;
    @(negedge clk); #1;
    chk("R10 hold when disabled", hold_connect, 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule